// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash. Every bus write (a one-cycle strobe with an address and a data byte) goes through a small state machine. The state machine recognises the unlock pair and the command byte that follows it. Complete sequences become one-cycle requests to the array engine:
- a program request, carrying a normalised byte address and the data byte;
- an erase request, marked either as one sector or as the whole chip.

A third outcome is the identification mode flag, together with the read data that mode supplies.

The bus address is interpreted according to a byte/word mode input. In word mode the bus carries a word address, and the block turns it into a byte address by appending a zero bit. In byte mode the bus carries the byte address itself. The unlock addresses follow the mode.

A boot region of parameterised size lies at either the top or the bottom of the byte address space. While a lock input is high, the block silently drops program and sector-erase requests that land in that region. The array, the high-voltage pin modes and glitch filtering live outside this block. So does the erase engine, which reports back through an erase-active input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is the first unlock cycle when it carries data AAh at bus address bits [15:0] = 5555h in word mode or AAAAh in byte mode. It is the second unlock cycle when it carries data 55h at 2AAAh in word mode or 5555h in byte mode. Only bits [15:0] of the bus address are compared.
- R2: The program sequence is both unlock cycles, then A0h at the first unlock address, then a write to any address. One clock after that last write, `prog_req` is high for exactly one cycle. At the same time `prog_addr` holds the byte address (word mode: bus address shifted left by one) and `prog_data` holds the data.
- R3: The sector erase sequence is unlock, 80h at the first unlock address, unlock again, then 30h at any address. One clock after the last write, `erase_req` pulses with `erase_chip` = 0. `erase_sector` is then the byte address divided by SECTOR_BYTES.
- R4: The chip erase sequence has the same six-cycle form but ends with 10h at the first unlock address. It gives an `erase_req` pulse with `erase_chip` = 1, and the boot lock does not suppress it.
- R5: Both unlock cycles followed by 90h at the first unlock address set `autosel` one clock later. A single F0h write at any address clears it.
- R6: While `autosel` is 1, `id_data` depends on byte address bits [2:1] of `rd_addr`:
  - 0 gives 40h;
  - 1 gives 13h for a top-boot build and B3h for a bottom-boot build;
  - 2 gives 01h when the address lies in the boot region and `boot_locked` is 1, otherwise 00h;
  - 3 gives 00h.
  While `autosel` is 0, `id_data` is 00h.
- R7: A write that does not fit the expected next cycle drops the partial sequence. A new sequence must then begin with a fresh first unlock cycle, and no request results from the dropped one.
- R8: A program sequence completed while `erase_active` is 1 produces no `prog_req`.
- R9: While `boot_locked` is 1, a program or sector-erase target inside the boot region produces no request.
- R10: Any write while `autosel` is 1 clears `autosel` and is decoded as the first cycle of a new sequence.
- R11: With TOP_BOOT = 1, the boot region is the highest BOOT_BYTES of the byte space: 7C000h–7FFFFh for the 19-bit default. With TOP_BOOT = 0 it is the lowest BOOT_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data byte |
| erase_active | input | 1 | Erase in progress in the array engine |
| boot_locked | input | 1 | Boot region protection is on |
| rd_addr | input | ADDR_W | Bus read address for identification reads |
| id_data | output | 8 | Identification read data |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program byte address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Erase scope: 1 = whole chip, 0 = one sector |
| erase_sector | output | ADDR_W-log2(SECTOR_BYTES) | Sector index for a sector erase |
| autosel | output | 1 | Identification mode active |

## Verification
The bench drives the byte-mode unlock addresses while in word mode. A decoder that ignored the mode would program from them. It breaks sequences midway with stray writes, including FFh to the first unlock address, then issues a data write. A decoder that resumed or kept the partial state would emit a spurious program. It targets the boot region boundary (7BFFFh against 7C000h) with the lock on and off, and completes programs while an erase runs. Either misstep would show a request that should have been dropped. It also starts a command straight out of identification mode, which catches a decoder that swallows the first unlock cycle or stays in that mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [2:0] {
      ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3
   } seq_state_t;

   localparam logic [7:0] CMD_KEY_A  = 8'hAA;
   localparam logic [7:0] CMD_KEY_B  = 8'h55;
   localparam logic [7:0] CMD_PGM    = 8'hA0;
   localparam logic [7:0] CMD_ERS    = 8'h80;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_SECT   = 8'h30;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
   localparam logic [7:0] IDV_MAKER  = 8'h40;
   localparam logic [7:0] IDV_TOP    = 8'h13;
   localparam logic [7:0] IDV_BOTTOM = 8'hB3;

   localparam logic [15:0] KEY1_WORD = 16'h5555;
   localparam logic [15:0] KEY2_WORD = 16'h2AAA;
   localparam logic [15:0] KEY1_BYTE = 16'hAAAA;
   localparam logic [15:0] KEY2_BYTE = 16'h5555;
endpackage

// File: rtl/fcd_addr_norm.sv
module fcd_addr_norm #(
   parameter int ADDR_W = 19
) (
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [ADDR_W-1:0] byte_addr
);
   always_comb begin
      if (byte_mode) byte_addr = bus_addr;
      else           byte_addr = {bus_addr[ADDR_W-2:0], 1'b0};
   end
endmodule

// File: rtl/fcd_boot_hit.sv
module fcd_boot_hit #(
   parameter int ADDR_W     = 19,
   parameter int BOOT_BYTES = 16384,
   parameter bit TOP_BOOT   = 1'b1
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic              in_boot
);
   localparam logic [ADDR_W:0]   SPACE     = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(SPACE - (ADDR_W+1)'(BOOT_BYTES));
   localparam logic [ADDR_W-1:0] BOOT_END  = ADDR_W'(BOOT_BYTES);

   generate
      if (TOP_BOOT) begin : g_top
         assign in_boot = (byte_addr >= BOOT_BASE);
      end else begin : g_bottom
         assign in_boot = (byte_addr < BOOT_END);
      end
   endgenerate
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
   import fcd_pkg::*;
#(
   parameter bit TOP_BOOT = 1'b1
) (
   input  logic       ident_on,
   input  logic [1:0] offset,
   input  logic       rd_in_boot,
   input  logic       boot_locked,
   output logic [7:0] id_data
);
   logic [7:0] dev_code;

   generate
      if (TOP_BOOT) begin : g_top_id
         assign dev_code = IDV_TOP;
      end else begin : g_bot_id
         assign dev_code = IDV_BOTTOM;
      end
   endgenerate

   always_comb begin
      id_data = 8'h00;
      if (ident_on) begin
         unique case (offset)
            2'd0: id_data = IDV_MAKER;
            2'd1: id_data = dev_code;
            2'd2: id_data = {7'd0, rd_in_boot & boot_locked};
            default: id_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int SECT_LOG = 10,
   localparam int SECT_W  = ADDR_W - SECT_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              wr_en,
   input  logic [15:0]       wr_lo,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_in_boot,
   input  logic              boot_locked,
   input  logic              erase_active,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              erase_req,
   output logic              erase_chip,
   output logic [SECT_W-1:0] erase_sector,
   output logic              autosel
);
   seq_state_t st_q, st_d;
   logic       key1_hit, key2_hit, guarded;
   logic       pgm_d, ers_d, chip_d, ident_d;

   assign key1_hit = (wr_lo == (byte_mode ? KEY1_BYTE : KEY1_WORD));
   assign key2_hit = (wr_lo == (byte_mode ? KEY2_BYTE : KEY2_WORD));
   assign guarded  = boot_locked & tgt_in_boot;

   always_comb begin
      st_d    = st_q;
      ident_d = autosel;
      pgm_d   = 1'b0;
      ers_d   = 1'b0;
      chip_d  = erase_chip;
      if (wr_en) begin
         ident_d = 1'b0;
         st_d    = ST_READ;
         unique case (st_q)
            ST_READ: if (key1_hit && wr_data == CMD_KEY_A) st_d = ST_UNL1;
            ST_UNL1: if (key2_hit && wr_data == CMD_KEY_B) st_d = ST_UNL2;
            ST_UNL2: begin
               if (key1_hit) begin
                  if (wr_data == CMD_PGM)        st_d = ST_PGM;
                  else if (wr_data == CMD_ERS)   st_d = ST_ERS1;
                  else if (wr_data == CMD_IDENT) ident_d = 1'b1;
               end
            end
            ST_PGM:  pgm_d = !erase_active && !guarded;
            ST_ERS1: if (key1_hit && wr_data == CMD_KEY_A) st_d = ST_ERS2;
            ST_ERS2: if (key2_hit && wr_data == CMD_KEY_B) st_d = ST_ERS3;
            ST_ERS3: begin
               if (wr_data == CMD_SECT) begin
                  if (!guarded) begin
                     ers_d  = 1'b1;
                     chip_d = 1'b0;
                  end
               end else if (key1_hit && wr_data == CMD_CHIP) begin
                  ers_d  = 1'b1;
                  chip_d = 1'b1;
               end
            end
            default: st_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_READ;
         autosel      <= 1'b0;
         prog_req     <= 1'b0;
         erase_req    <= 1'b0;
         erase_chip   <= 1'b0;
         prog_addr    <= '0;
         prog_data    <= '0;
         erase_sector <= '0;
      end else begin
         st_q       <= st_d;
         autosel    <= ident_d;
         prog_req   <= pgm_d;
         erase_req  <= ers_d;
         erase_chip <= chip_d;
         if (pgm_d) begin
            prog_addr <= tgt_addr;
            prog_data <= wr_data;
         end
         if (ers_d && !chip_d) erase_sector <= tgt_addr[ADDR_W-1:SECT_LOG];
      end
   end

   // R2: requests only ever follow a bus write, and never both at once
   a_r2_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req || erase_req) |-> $past(wr_en));
   a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && erase_req));
   // R3: a sector erase is always triggered by the sector code
   a_r3_sector_code: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !erase_chip) |-> ($past(wr_data) == CMD_SECT));
   // R5: identification mode is entered only by its command byte
   a_r5_ident_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(autosel) |-> ($past(wr_data) == CMD_IDENT));
   // R8: no program while an erase runs
   a_r8_no_pgm_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !$past(erase_active));
   // R9: locked boot region is never a program or sector-erase target
   a_r9_lock_pgm: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !$past(boot_locked && tgt_in_boot));
   a_r9_lock_sector: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !erase_chip) |-> !$past(boot_locked && tgt_in_boot));
   // R10: identification mode only ends on a write
   a_r10_ident_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(autosel) |-> $past(wr_en));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int ADDR_W       = 19,
   parameter int SECTOR_BYTES = 1024,
   parameter int BOOT_BYTES   = 16384,
   parameter bit TOP_BOOT     = 1'b1,
   localparam int SECT_LOG    = $clog2(SECTOR_BYTES),
   localparam int SECT_W      = ADDR_W - SECT_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              erase_active,
   input  logic              boot_locked,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        id_data,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              erase_req,
   output logic              erase_chip,
   output logic [SECT_W-1:0] erase_sector,
   output logic              autosel
);
   generate
      if (ADDR_W < 17) begin : g_bad_addr
         $error("ADDR_W must cover the 16-bit unlock field plus one bit");
      end
      if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES < 2) begin : g_bad_sect
         $error("SECTOR_BYTES must be a power of two");
      end
      if ((BOOT_BYTES & (BOOT_BYTES - 1)) != 0 || $clog2(BOOT_BYTES) >= ADDR_W) begin : g_bad_boot
         $error("BOOT_BYTES must be a power of two below the address space");
      end
   endgenerate

   logic [ADDR_W-1:0] wr_byte, rd_byte;
   logic              wr_in_boot, rd_in_boot;

   fcd_addr_norm #(.ADDR_W(ADDR_W)) i_wr_norm (
      .byte_mode(byte_mode), .bus_addr(wr_addr), .byte_addr(wr_byte));
   fcd_addr_norm #(.ADDR_W(ADDR_W)) i_rd_norm (
      .byte_mode(byte_mode), .bus_addr(rd_addr), .byte_addr(rd_byte));

   fcd_boot_hit #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .TOP_BOOT(TOP_BOOT)) i_wr_boot (
      .byte_addr(wr_byte), .in_boot(wr_in_boot));
   fcd_boot_hit #(.ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .TOP_BOOT(TOP_BOOT)) i_rd_boot (
      .byte_addr(rd_byte), .in_boot(rd_in_boot));

   fcd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_LOG(SECT_LOG)) i_fsm (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
      .wr_lo(wr_addr[15:0]), .wr_data(wr_data), .tgt_addr(wr_byte),
      .tgt_in_boot(wr_in_boot), .boot_locked(boot_locked),
      .erase_active(erase_active), .prog_req(prog_req), .prog_addr(prog_addr),
      .prog_data(prog_data), .erase_req(erase_req), .erase_chip(erase_chip),
      .erase_sector(erase_sector), .autosel(autosel));

   fcd_id_rom #(.TOP_BOOT(TOP_BOOT)) i_id (
      .ident_on(autosel), .offset(rd_byte[2:1]), .rd_in_boot(rd_in_boot),
      .boot_locked(boot_locked), .id_data(id_data));

   // R6: outside identification mode the read path is quiet
   a_r6_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !autosel |-> (id_data == 8'h00));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
   localparam int AW = 19;
   localparam logic [AW-1:0] BOOT_BASE = 19'h7C000;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          byte_mode = 1'b0, wr_en = 1'b0, erase_active = 1'b0, boot_locked = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0]    wr_data = '0, id_data, prog_data;
   logic          prog_req, erase_req, erase_chip, autosel;
   logic [AW-1:0] prog_addr;
   logic [8:0]    erase_sector;

   int checks = 0, errors = 0;
   int ms = 0;
   bit mauto = 0, e_prog = 0, e_ers = 0, e_chip = 0;
   logic [AW-1:0] e_paddr;
   logic [7:0]    e_pdata;
   logic [8:0]    e_sect;

   always #2 clk = ~clk;

   flash_cmd_decoder i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .erase_active(erase_active),
      .boot_locked(boot_locked), .rd_addr(rd_addr), .id_data(id_data),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_req(erase_req), .erase_chip(erase_chip),
      .erase_sector(erase_sector), .autosel(autosel));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] key1(input bit bm);
      return bm ? 19'h0AAAA : 19'h05555;
   endfunction
   function automatic logic [AW-1:0] key2(input bit bm);
      return bm ? 19'h05555 : 19'h02AAA;
   endfunction
   function automatic logic [AW-1:0] to_byte(input bit bm, input logic [AW-1:0] a);
      return bm ? a : {a[AW-2:0], 1'b0};
   endfunction

   // reference model of the requirements
   task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d);
      bit u1 = (a[15:0] == key1(byte_mode)[15:0]);
      bit u2 = (a[15:0] == key2(byte_mode)[15:0]);
      logic [AW-1:0] ba = to_byte(byte_mode, a);
      bit guard = boot_locked && (ba >= BOOT_BASE);
      int nxt = 0;
      e_prog = 0; e_ers = 0; mauto = 0;
      case (ms)
         0: if (u1 && d == 8'hAA) nxt = 1;
         1: if (u2 && d == 8'h55) nxt = 2;
         2: if (u1) begin
               if (d == 8'hA0) nxt = 3;
               else if (d == 8'h80) nxt = 4;
               else if (d == 8'h90) mauto = 1;
            end
         3: if (!erase_active && !guard) begin
               e_prog = 1; e_paddr = ba; e_pdata = d;
            end
         4: if (u1 && d == 8'hAA) nxt = 5;
         5: if (u2 && d == 8'h55) nxt = 6;
         6: if (d == 8'h30) begin
               if (!guard) begin e_ers = 1; e_chip = 0; e_sect = ba[AW-1:10]; end
            end else if (u1 && d == 8'h10) begin
               e_ers = 1; e_chip = 1;
            end
         default: nxt = 0;
      endcase
      ms = nxt;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
      model_write(a, d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk(prog_req == e_prog, req, "prog_req", prog_req, e_prog);
      if (e_prog) begin
         chk(prog_addr == e_paddr, req, "prog_addr", prog_addr, e_paddr);
         chk(prog_data == e_pdata, req, "prog_data", prog_data, e_pdata);
      end
      chk(erase_req == e_ers, req, "erase_req", erase_req, e_ers);
      if (e_ers) begin
         chk(erase_chip == e_chip, req, "erase_chip", erase_chip, e_chip);
         if (!e_chip) chk(erase_sector == e_sect, req, "erase_sector", erase_sector, e_sect);
      end
      chk(autosel == mauto, req, "autosel", autosel, mauto);
   endtask

   task automatic unlock(input string req);
      wr(key1(byte_mode), 8'hAA, req);
      wr(key2(byte_mode), 8'h55, req);
   endtask

   task automatic id_read(input logic [AW-1:0] a, input string req);
      logic [AW-1:0] ba = to_byte(byte_mode, a);
      logic [7:0] e = 8'h00;
      rd_addr = a;
      #1;
      if (mauto) begin
         case (ba[2:1])
            2'd0: e = 8'h40;
            2'd1: e = 8'h13;
            2'd2: e = {7'd0, boot_locked && (ba >= BOOT_BASE)};
            default: e = 8'h00;
         endcase
      end
      chk(id_data == e, req, "id_data", id_data, e);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // reset state
      chk(prog_req == 0 && erase_req == 0, "R2", "reset requests", {prog_req, erase_req}, 0);
      chk(autosel == 0, "R5", "reset autosel", autosel, 0);
      rst_n = 1'b1;
      id_read(19'h00000, "R6");

      // R1/R2: word mode program
      unlock("R1"); wr(key1(0), 8'hA0, "R2"); wr(19'h01234, 8'h5A, "R2");
      // R1: byte mode program
      byte_mode = 1; unlock("R1"); wr(key1(1), 8'hA0, "R2"); wr(19'h12345, 8'hC3, "R1");
      // R1: byte-mode keys used in word mode give nothing
      byte_mode = 0;
      wr(19'h0AAAA, 8'hAA, "R1"); wr(19'h05555, 8'h55, "R1");
      wr(19'h0AAAA, 8'hA0, "R1"); wr(19'h00100, 8'h11, "R1");
      // R3: sector erase, R4: chip erase (locked)
      unlock("R3"); wr(key1(0), 8'h80, "R3"); unlock("R3"); wr(19'h00A00, 8'h30, "R3");
      boot_locked = 1;
      unlock("R4"); wr(key1(0), 8'h80, "R4"); unlock("R4"); wr(key1(0), 8'h10, "R4");
      // R9 / R11: boundary with lock on
      unlock("R9"); wr(key1(0), 8'hA0, "R9"); wr(19'h3E000, 8'h22, "R9");
      unlock("R11"); wr(key1(0), 8'hA0, "R11"); wr(19'h3DFFF, 8'h23, "R11");
      unlock("R9"); wr(key1(0), 8'h80, "R9"); unlock("R9"); wr(19'h3FFFF, 8'h30, "R9");
      boot_locked = 0;
      unlock("R11"); wr(key1(0), 8'hA0, "R11"); wr(19'h3E000, 8'h24, "R11");
      // R8: erase running
      erase_active = 1;
      unlock("R8"); wr(key1(0), 8'hA0, "R8"); wr(19'h00200, 8'h25, "R8");
      erase_active = 0;
      // R5/R6: identification mode
      unlock("R5"); wr(key1(0), 8'h90, "R5");
      id_read(19'h00000, "R6"); id_read(19'h00001, "R6");
      id_read(19'h3E002, "R6"); boot_locked = 1; id_read(19'h3E002, "R6");
      id_read(19'h01002, "R6"); id_read(19'h00003, "R6"); boot_locked = 0;
      wr(19'h00000, 8'hF0, "R5"); id_read(19'h00000, "R6");
      // R10: command straight out of identification mode
      unlock("R10"); wr(key1(0), 8'h90, "R10");
      unlock("R10"); wr(key1(0), 8'hA0, "R10"); wr(19'h00300, 8'h77, "R10");
      // R7: abort by stray write
      unlock("R7"); wr(key1(0), 8'hFF, "R7"); wr(19'h00400, 8'h88, "R7");
      wr(key1(0), 8'hAA, "R7"); wr(key1(0), 8'hFF, "R7");
      wr(key2(0), 8'h55, "R7"); wr(key1(0), 8'hA0, "R7"); wr(19'h00500, 8'h99, "R7");

      // constrained random sequences
      for (int i = 0; i < 400; i++) begin
         int kind = $urandom_range(0, 6);
         logic [AW-1:0] ra = AW'($urandom);
         logic [7:0] rd = 8'($urandom);
         if ($urandom_range(0, 7) == 0) ra = BOOT_BASE | AW'($urandom_range(0, 16383));
         if (ms == 0) byte_mode = $urandom_range(0, 1) == 1;
         boot_locked  = $urandom_range(0, 2) == 0;
         erase_active = $urandom_range(0, 4) == 0;
         if (!byte_mode) ra[AW-1] = 1'b0;
         case (kind)
            0: begin unlock("R2"); wr(key1(byte_mode), 8'hA0, "R2"); wr(ra, rd, "R2"); end
            1: begin unlock("R3"); wr(key1(byte_mode), 8'h80, "R3"); unlock("R3"); wr(ra, 8'h30, "R3"); end
            2: begin unlock("R4"); wr(key1(byte_mode), 8'h80, "R4"); unlock("R4"); wr(key1(byte_mode), 8'h10, "R4"); end
            3: begin unlock("R5"); wr(key1(byte_mode), 8'h90, "R5"); id_read(ra, "R6"); end
            4: wr(ra, 8'hF0, "R5");
            5: begin unlock("R7"); wr(ra, rd, "R7"); end
            default: wr(ra, rd, "R7");
         endcase
         id_read(ra, "R6");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule